// File: doc/BRIEF.md
# Buffered-Update PWM Channel

This block is one channel of a pulse-width modulator. A 16-bit counter advances on one of several externally generated tick strobes, chosen by a prescale code, and the counter value is compared with a duty value to form the output waveform. The counter either ramps up and wraps (edge-aligned) or ramps up and back down (centre-aligned), and a polarity bit picks which output level is the active one. After every completed period the channel raises a one-cycle end-of-period pulse.

Software reaches the channel through a small word-addressed register group: a mode word, a duty value, a period value, a read-only counter view and an update slot. While the channel is running, the duty and period values cannot be written directly; instead a value written to the update slot is held and committed only at the next period end, to either the duty or the period as a mode bit chooses. The waveform therefore changes only at period boundaries. The channel enable and the tick dividers live outside the block.

The counter is a three-state machine: IDLE (disabled, counter at zero), RISE (counting up) and FALL (counting down, centre-aligned only). Transitions: IDLE to RISE when the enable goes high; RISE to RISE with the counter wrapping to zero at the period value in edge-aligned mode (a period end); RISE to FALL at the period value in centre-aligned mode; FALL to RISE when the counter is at zero on a tick (a period end); any state to IDLE when the enable is low.

Top module: `pwm_chan`

## Requirements
- R1: Register offsets are mode 0x00, duty 0x04, period 0x08, counter 0x0C and update 0x10; the counter register is read-only (writes are ignored) and the update register reads as zero.
- R2: In the mode word, bits 3:0 are the prescale code, bit 8 selects centre alignment, bit 9 is the active output level and bit 10 selects the update target (0 duty, 1 period); all other bits are dropped on write and read as zero.
- R3: Duty, period and counter are 16 bits; bits above 15 of write data are dropped and read back as zero.
- R4: In edge-aligned mode the counter steps 0,1,...,P and then returns to 0 with a period end, so a period lasts P+1 ticks.
- R5: In centre-aligned mode the counter rises from 0 to P and falls from P back to 0, holding each end for one tick, so a period lasts 2(P+1) ticks, twice the edge-aligned length.
- R6: The counter advances only in cycles where tick input number equal to the prescale code is high; with a code at or above the number of tick inputs the counter stays frozen.
- R7: While running, the output equals mode bit 9 while the counter is below the duty value and its inverse otherwise.
- R8: period_end is high for exactly the one cycle after each tick that completes a period.
- R9: While enabled, a write to the update register leaves duty and period unchanged until the next period end, where the latest written value replaces the duty (bit 10 = 0) or the period (bit 10 = 1).
- R10: Direct writes to the duty and period registers take effect only while disabled and are ignored while enabled; an update-register write while disabled lands in its target on the next clock.
- R11: While disabled the counter is held at 0, the output sits at the inverse of mode bit 9 and no period end is signalled; on enable counting restarts from 0.
- R12: After reset all registers read zero and the output is high (inactive for an active level of 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel run enable from the global control |
| tick_in | input | NTICK | Divided tick strobes, one per prescale code |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset inside the channel register group |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr (combinational) |
| pwm_out | output | 1 | PWM waveform |
| period_end | output | 1 | One-cycle pulse after each completed period |

## Verification
The hardest case is an update-register write that lands while the channel runs and must stay invisible until the boundary: the bench waits for a period-end pulse, writes immediately after it, reads the target register back well before the next boundary, then waits for the following pulse and reads again, once with each update target. A cycle-by-cycle scoreboard predicts output and pulse from the requirements across mode switches made mid-period (edge to centre alignment, prescale changes, a frozen prescale code), so turnarounds caught in the falling phase are covered too.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_MODE   = 5'h00;
    localparam logic [REG_AW-1:0] OFS_DUTY   = 5'h04;
    localparam logic [REG_AW-1:0] OFS_PERIOD = 5'h08;
    localparam logic [REG_AW-1:0] OFS_COUNT  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_UPDATE = 5'h10;

    localparam int MB_CENTER = 8;
    localparam int MB_POL    = 9;
    localparam int MB_UPSEL  = 10;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_RISE = 2'd1,
        CS_FALL = 2'd2
    } cnt_state_e;

    typedef struct packed {
        logic       upsel;
        logic       pol;
        logic       center;
        logic [3:0] pre;
    } mode_t;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_chan_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              boundary,
    output mode_t             mode,
    output logic [CW-1:0]     duty,
    output logic [CW-1:0]     period
);

    logic [CW-1:0] pend_val;
    logic          pend;
    logic          commit;
    logic          unused_hi;

    assign unused_hi = ^wdata[DW-1:CW];
    assign commit    = pend && (boundary || !chan_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= '0;
            duty     <= '0;
            period   <= '0;
            pend_val <= '0;
            pend     <= 1'b0;
        end else begin
            if (wr_en && addr == OFS_MODE) begin
                mode.pre    <= wdata[3:0];
                mode.center <= wdata[MB_CENTER];
                mode.pol    <= wdata[MB_POL];
                mode.upsel  <= wdata[MB_UPSEL];
            end
            if (wr_en && !chan_en && addr == OFS_DUTY)
                duty <= wdata[CW-1:0];
            if (wr_en && !chan_en && addr == OFS_PERIOD)
                period <= wdata[CW-1:0];
            if (commit) begin
                if (mode.upsel) period <= pend_val;
                else            duty   <= pend_val;
                pend <= 1'b0;
            end
            if (wr_en && addr == OFS_UPDATE) begin
                pend_val <= wdata[CW-1:0];
                pend     <= 1'b1;
            end
        end
    end

    // R9 / R10: while running, duty and period move only at a boundary
    a_r9_hold_between_bounds: assert property (
        @(posedge clk) disable iff (!rst_n)
        (chan_en && !boundary) |=> ($stable(duty) && $stable(period))
    );

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter
    import pwm_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          center,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          boundary,
    output logic          eop
);

    cnt_state_e    st, st_nx;
    logic [CW-1:0] cnt_nx;

    // next-state and boundary decode
    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        boundary = 1'b0;
        if (!en) begin
            st_nx  = CS_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (st)
                CS_IDLE: begin
                    st_nx  = CS_RISE;
                    cnt_nx = '0;
                end
                CS_RISE: begin
                    if (tick) begin
                        if (cnt >= period) begin
                            if (center) begin
                                st_nx  = CS_FALL;
                                cnt_nx = period;
                            end else begin
                                cnt_nx   = '0;
                                boundary = 1'b1;
                            end
                        end else begin
                            cnt_nx = cnt + 1'b1;
                        end
                    end
                end
                CS_FALL: begin
                    if (tick) begin
                        if (cnt == '0) begin
                            st_nx    = CS_RISE;
                            boundary = 1'b1;
                        end else begin
                            cnt_nx = cnt - 1'b1;
                        end
                    end
                end
                default: begin
                    st_nx  = CS_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CS_IDLE;
            cnt <= '0;
            eop <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            eop <= boundary;
        end
    end

    assign running = (st != CS_IDLE);

    // R4: a running counter never exceeds the period value
    a_r4_cnt_within_period: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st != CS_IDLE) |-> (cnt <= period)
    );

    // R5: falling phase steps down by one per tick
    a_r5_fall_step: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st == CS_FALL && en && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)
    );

    // R6: no tick, no movement
    a_r6_frozen_without_tick: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st != CS_IDLE && en && !tick) |=> $stable(cnt)
    );

    // R11: disabled holds the counter at zero with no period end
    a_r11_idle_zero: assert property (
        @(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && !eop)
    );

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int CW    = 16,
    parameter int NTICK = 11,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [NTICK-1:0]  tick_in,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              pwm_out,
    output logic              period_end
);

    mode_t         mode;
    logic [CW-1:0] duty;
    logic [CW-1:0] period;
    logic [CW-1:0] cnt;
    logic          running;
    logic          boundary;
    logic          tick_sel;

    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NTICK; i++)
            if (mode.pre == 4'(i)) tick_sel = tick_in[i];
    end

    pwm_chan_regs #(.CW(CW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .boundary (boundary),
        .mode     (mode),
        .duty     (duty),
        .period   (period)
    );

    pwm_chan_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (chan_en),
        .tick     (tick_sel),
        .center   (mode.center),
        .period   (period),
        .cnt      (cnt),
        .running  (running),
        .boundary (boundary),
        .eop      (period_end)
    );

    assign pwm_out = (running && cnt < duty) ? mode.pol : !mode.pol;

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_MODE: begin
                rdata[3:0]       = mode.pre;
                rdata[MB_CENTER] = mode.center;
                rdata[MB_POL]    = mode.pol;
                rdata[MB_UPSEL]  = mode.upsel;
            end
            OFS_DUTY:   rdata[CW-1:0] = duty;
            OFS_PERIOD: rdata[CW-1:0] = period;
            OFS_COUNT:  rdata[CW-1:0] = cnt;
            default:    rdata = '0;
        endcase
    end

    // R11: disabled output sits at the inactive level
    a_r11_inactive_out: assert property (
        @(posedge clk) disable iff (!rst_n)
        !chan_en |=> (pwm_out != mode.pol)
    );

    // R8: a period end only follows a cycle in which the channel ran
    a_r8_eop_after_run: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(period_end) |-> $past(chan_en)
    );

endmodule

// File: tb/pwm_chan_test.sv
`timescale 1ns/1ps
module pwm_chan_test;

    localparam int CW = 16;
    localparam int NT = 11;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chan_en = 1'b0;
    logic [NT-1:0] tick_in = '0;
    logic          wr_en = 1'b0;
    logic [4:0]    addr = 5'h0C;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          pwm_out;
    logic          period_end;

    pwm_chan #(.CW(CW), .NTICK(NT), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tick_in(tick_in),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pwm_out(pwm_out), .period_end(period_end)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct { int cnt; bit out; bit eop; } exp_t;
    exp_t q[$];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // tick strobes: input k is high once every 2^k cycles
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            for (int k = 0; k < NT; k++) tick_in[k] = ((cyc % (1 << k)) == 0);
        end
    end

    // reference model built from the requirements; pushes one expected item per edge
    int m_st, m_cnt, m_duty, m_per, m_mode, m_pv;
    bit m_pend, m_eop;
    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_duty = 0; m_per = 0; m_mode = 0;
            m_pv = 0; m_pend = 0; m_eop = 0;
        end else begin
            int code, nst, ncnt, nmode, nduty, nper, npv;
            bit t, bnd, npend;
            code = m_mode & 15;
            t = (code < NT) ? tick_in[code] : 1'b0;
            bnd = 0; nst = m_st; ncnt = m_cnt;
            if (!chan_en) begin nst = 0; ncnt = 0; end
            else if (m_st == 0) begin nst = 1; ncnt = 0; end
            else if (m_st == 1) begin
                if (t) begin
                    if (m_cnt >= m_per) begin
                        if (m_mode[8]) begin nst = 2; ncnt = m_per; end
                        else begin ncnt = 0; bnd = 1; end
                    end else ncnt = m_cnt + 1;
                end
            end else if (t) begin
                if (m_cnt == 0) begin nst = 1; bnd = 1; end
                else ncnt = m_cnt - 1;
            end
            nmode = m_mode; nduty = m_duty; nper = m_per; npv = m_pv; npend = m_pend;
            if (wr_en && addr == 5'h00) nmode = wdata & 32'h70F;
            if (wr_en && addr == 5'h04 && !chan_en) nduty = wdata & 32'hFFFF;
            if (wr_en && addr == 5'h08 && !chan_en) nper = wdata & 32'hFFFF;
            if (m_pend && (bnd || !chan_en)) begin
                if (m_mode[10]) nper = m_pv; else nduty = m_pv;
                npend = 0;
            end
            if (wr_en && addr == 5'h10) begin npv = wdata & 32'hFFFF; npend = 1; end
            m_st = nst; m_cnt = ncnt; m_mode = nmode; m_duty = nduty;
            m_per = nper; m_pv = npv; m_pend = npend; m_eop = bnd;
        end
        e.cnt = m_cnt;
        e.eop = m_eop;
        e.out = (m_st != 0 && m_cnt < m_duty) ? m_mode[9] : !m_mode[9];
        q.push_back(e);
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (rst_n) begin
                    chk(pwm_out == e.out, "R7", "pwm_out", pwm_out, e.out);
                    chk(period_end == e.eop, "R8", "period_end", period_end, e.eop);
                    if (addr == 5'h0C)
                        chk(rdata == e.cnt, "R4/R5", "counter", rdata, e.cnt);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 5'h0C;
    endtask

    task automatic rdv(input logic [4:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
        #2 addr = 5'h0C;
    endtask

    task automatic rd(input logic [4:0] a, input int exp, input string req);
        int v;
        rdv(a, v);
        chk(v == exp, req, "register read", v, exp);
    endtask

    task automatic wait_eop();
        do @(negedge clk); while (!period_end);
    endtask

    task automatic meas(input int exp, input string req);
        int n = 0;
        wait_eop();
        do begin @(negedge clk); n++; end while (!period_end);
        chk(n == exp, req, "period length", n, exp);
    endtask

    initial begin
        int v1, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        rd(5'h00, 0, "R12"); rd(5'h04, 0, "R12"); rd(5'h08, 0, "R12");
        chk(pwm_out == 1'b1, "R12", "reset output", pwm_out, 1);
        // R2 mode masking, R3 width masking
        wr(5'h00, 32'hFFFF_FA03); rd(5'h00, 32'h0000_0203, "R2");
        wr(5'h04, 32'h0001_2345); rd(5'h04, 32'h2345, "R3");
        wr(5'h08, 32'hABCD_0009); rd(5'h08, 32'h0009, "R3");
        // edge-aligned run, P=9, duty 3
        wr(5'h04, 3); wr(5'h00, 0);
        @(negedge clk); chan_en = 1'b1;
        repeat (25) @(negedge clk);
        meas(10, "R4");
        // R9 deferred duty update
        wait_eop(); wr(5'h10, 6); rd(5'h04, 3, "R9");
        wait_eop(); rd(5'h04, 6, "R9");
        // R10 direct writes ignored while enabled
        wr(5'h04, 1); rd(5'h04, 6, "R10");
        wr(5'h08, 2); rd(5'h08, 9, "R10");
        // R9 deferred period update
        wr(5'h00, 32'h400);
        wait_eop(); wr(5'h10, 4); rd(5'h08, 9, "R9");
        wait_eop(); rd(5'h08, 4, "R9"); rd(5'h04, 6, "R9");
        meas(5, "R4");
        // centre-aligned, active high, update targets duty
        wr(5'h00, 32'h300);
        meas(10, "R5");
        wr(5'h10, 2);
        wait_eop(); rd(5'h04, 2, "R9");
        repeat (30) @(negedge clk);
        // prescale code 2: tick every 4 cycles
        wr(5'h00, 32'h002);
        meas(20, "R6");
        repeat (20) @(negedge clk);
        // code beyond the tick inputs freezes the counter
        wr(5'h00, 32'h00F);
        rdv(5'h0C, v1);
        repeat (8) @(negedge clk);
        rdv(5'h0C, v2);
        chk(v1 == v2, "R6", "frozen counter", v2, v1);
        // disable
        wr(5'h00, 0);
        @(negedge clk); chan_en = 1'b0;
        @(negedge clk);
        rd(5'h0C, 0, "R11");
        chk(pwm_out == 1'b1, "R11", "disabled output", pwm_out, 1);
        chk(period_end == 1'b0, "R11", "disabled period_end", period_end, 0);
        // R1 counter read-only, update reads zero
        wr(5'h0C, 32'h55); rd(5'h0C, 0, "R1");
        wr(5'h10, 7); rd(5'h04, 7, "R10");
        rd(5'h10, 0, "R1");
        // period 0: a period end after every tick
        wr(5'h08, 0);
        @(negedge clk); chan_en = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(period_end == 1'b1, "R8", "period 0 pulse", period_end, 1);
        end
        repeat (10) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule